// File: doc/BRIEF.md
# Parallel-Bus ADC Conversion Sequencer

This block sits on the host side of a multiplexed analog-to-digital converter that shares one 8-bit parallel bus for configuration and results. A user request carries a five-bit channel address and three format options. The sequencer drives the configuration byte onto the bus under chip select and pulses the write strobe. The converter latches the channel and starts converting on the rising edge of that strobe.

The sequencer then releases the bus and waits for the converter's active-low completion interrupt. It reads one byte in 8-bit mode, or two bytes in 10-bit mode. It assembles the result word and presents it together with a one-cycle done pulse. It also produces the converter's clock from the system clock. A watchdog counts periods of that same clock while the interrupt is pending. If the interrupt does not arrive in time, the watchdog ends the conversion with an error pulse.

Top module: `pbadc_seq`

## Requirements
- R1: While `rst_ni` is low and after its release with no request, `cs_no`, `wr_no` and `rd_no` are high, `bus_oe_o`, `busy_o`, `done_o` and `err_o` are low.
- R2: `wr_no` is low only while `cs_no` is low. `bus_oe_o` is high from before `wr_no` falls until after `wr_no` rises, and exactly one write strobe is issued per accepted request.
- R3: The configuration byte on `bus_o` at the rising edge of `wr_no` has the channel address `chan_i` in bits 4:0, `uns_i` in bit 5, `res8_i` in bit 6 and `left_i` in bit 7.
- R4: `bus_oe_o` is low whenever `rd_no` is low, and `rd_no` is low only while `cs_no` is low.
- R5: No read strobe is issued before `int_ni` has been seen low after the write strobe.
- R6: With `res8_i`=1 exactly one read strobe is issued and `data_o` = {2'b00, byte read}.
- R7: With `res8_i`=0 and `left_i`=0, two read strobes are issued and `data_o` = bits 9:0 of {second byte, first byte}.
- R8: With `res8_i`=0 and `left_i`=1, two read strobes are issued and `data_o` = bits 15:6 of {first byte, second byte}.
- R9: `busy_o` is high from the cycle after a request is accepted until the done or error pulse. `done_o` is a single-cycle pulse with `busy_o` low, and `data_o` is valid in that cycle.
- R10: If `int_ni` stays high for `WDOG_LIMIT` converter clock periods after the write, `err_o` pulses for one cycle, no read strobe is issued, and the block returns to idle and accepts the next request.
- R11: `req_i` is ignored while `busy_o` is high. It produces no further write strobe and does not change the configuration byte.
- R12: `adc_clk_o` is a square wave with a period of 2*`CLK_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request, accepted in idle |
| chan_i | input | 5 | Multiplexer channel address |
| uns_i | input | 1 | Unsigned/signed format select |
| res8_i | input | 1 | 1 selects 8-bit, 0 selects 10-bit resolution |
| left_i | input | 1 | 1 selects left-justified, 0 right-justified |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle watchdog timeout pulse |
| data_o | output | 10 | Assembled conversion result |
| adc_clk_o | output | 1 | Clock to the converter |
| cs_no | output | 1 | Converter chip select, active low |
| wr_no | output | 1 | Write strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| int_ni | input | 1 | Conversion complete interrupt, active low |
| bus_o | output | 8 | Bus value driven toward the converter |
| bus_oe_o | output | 1 | Bus output enable |
| bus_i | input | 8 | Bus value read from the converter |

## Verification
Two situations are hard to reach: a request that arrives while a conversion is pending, and a conversion that never completes. The converter model in the bench takes a programmable interrupt delay, and a delay of zero means the interrupt is never given. With that setting the watchdog window is checked against bounds derived from the converter clock period. A long delay holds the block in its wait state, and during that wait a second request with a different channel is pulsed. The model records every write and read strobe and their bus ownership, so protocol errors show up as counts at the ports.

// File: rtl/pbadc_pkg.sv
package pbadc_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 10;
  localparam int CHAN_W = 5;

  typedef struct packed {
    logic              left;
    logic              res8;
    logic              uns;
    logic [CHAN_W-1:0] chan;
  } cfg_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_SET,
    ST_WR_LOW,
    ST_WR_HOLD,
    ST_WAIT,
    ST_RD_SET,
    ST_RD_LOW,
    ST_RD_GAP,
    ST_DONE,
    ST_FAIL
  } state_t;

endpackage

// File: rtl/pbadc_clkdiv.sv
module pbadc_clkdiv #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic adc_clk_o,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clk_q, clk_d;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == CW'(DIV - 1));
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    clk_d  = wrap ? ~clk_q : clk_q;
    tick_o = wrap & ~clk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign adc_clk_o = clk_q;

  // R12: a tick always announces a rising converter clock edge
  a_r12_tick_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> $rose(adc_clk_o));

endmodule

// File: rtl/pbadc_wdog.sv
module pbadc_wdog #(
  parameter int LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    expired_o = (cnt_q == CW'(LIMIT));
    if (!en_i)                      cnt_d = '0;
    else if (tick_i && !expired_o)  cnt_d = cnt_q + 1'b1;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R10: the window count never passes its limit
  a_r10_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));

  // R10: the count restarts whenever the window is closed
  a_r10_clear_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/pbadc_assemble.sv
module pbadc_assemble
  import pbadc_pkg::*;
(
  input  logic              res8_i,
  input  logic              left_i,
  input  logic [BYTE_W-1:0] first_i,
  input  logic [BYTE_W-1:0] second_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAIR_W = 2 * BYTE_W;

  logic [PAIR_W-1:0] pair;

  always_comb begin
    pair = left_i ? {first_i, second_i} : {second_i, first_i};
    if (res8_i)      word_o = {{(WORD_W-BYTE_W){1'b0}}, first_i};
    else if (left_i) word_o = pair[PAIR_W-1 -: WORD_W];
    else             word_o = pair[WORD_W-1:0];
  end

endmodule

// File: rtl/pbadc_seq.sv
module pbadc_seq
  import pbadc_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int WDOG_LIMIT = 32,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              uns_i,
  input  logic              res8_i,
  input  logic              left_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] data_o,
  output logic              adc_clk_o,
  output logic              cs_no,
  output logic              wr_no,
  output logic              rd_no,
  input  logic              int_ni,
  output logic [BYTE_W-1:0] bus_o,
  output logic              bus_oe_o,
  input  logic [BYTE_W-1:0] bus_i
);
  localparam int SCW = $clog2(STROBE_CYC + 1);

  state_t            st_q, st_d;
  cfg_t              cfg_q, cfg_d;
  logic [SCW-1:0]    sc_q, sc_d;
  logic [BYTE_W-1:0] b0_q, b0_d, b1_q, b1_d;
  logic              second_q, second_d;
  logic              tick, expired, strobe_last, more;

  pbadc_clkdiv #(.DIV(CLK_DIV)) u_clkdiv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adc_clk_o(adc_clk_o),
    .tick_o   (tick)
  );

  pbadc_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (st_q == ST_WAIT),
    .tick_i   (tick),
    .expired_o(expired)
  );

  pbadc_assemble u_asm (
    .res8_i  (cfg_q.res8),
    .left_i  (cfg_q.left),
    .first_i (b0_q),
    .second_i(b1_q),
    .word_o  (data_o)
  );

  // next-state logic
  always_comb begin
    st_d        = st_q;
    cfg_d       = cfg_q;
    sc_d        = '0;
    b0_d        = b0_q;
    b1_d        = b1_q;
    second_d    = second_q;
    strobe_last = (sc_q == SCW'(STROBE_CYC - 1));
    more        = !cfg_q.res8 && !second_q;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        cfg_d    = '{left: left_i, res8: res8_i, uns: uns_i, chan: chan_i};
        second_d = 1'b0;
        st_d     = ST_WR_SET;
      end
      ST_WR_SET:  st_d = ST_WR_LOW;
      ST_WR_LOW: begin
        sc_d = sc_q + 1'b1;
        if (strobe_last) st_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: st_d = ST_WAIT;
      ST_WAIT: begin
        if (!int_ni)      st_d = ST_RD_SET;
        else if (expired) st_d = ST_FAIL;
      end
      ST_RD_SET:  st_d = ST_RD_LOW;
      ST_RD_LOW: begin
        sc_d = sc_q + 1'b1;
        if (strobe_last) begin
          if (second_q) b1_d = bus_i;
          else          b0_d = bus_i;
          st_d = ST_RD_GAP;
        end
      end
      ST_RD_GAP: begin
        if (more) begin
          second_d = 1'b1;
          st_d     = ST_RD_SET;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_DONE:  st_d = ST_IDLE;
      ST_FAIL:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cfg_q    <= '0;
      sc_q     <= '0;
      b0_q     <= '0;
      b1_q     <= '0;
      second_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cfg_q    <= cfg_d;
      sc_q     <= sc_d;
      b0_q     <= b0_d;
      b1_q     <= b1_d;
      second_q <= second_d;
    end
  end

  // pin decode
  always_comb begin
    bus_o    = cfg_q;
    bus_oe_o = (st_q == ST_WR_SET) || (st_q == ST_WR_LOW) || (st_q == ST_WR_HOLD);
    wr_no    = (st_q != ST_WR_LOW);
    rd_no    = (st_q != ST_RD_LOW);
    cs_no    = !(bus_oe_o || (st_q == ST_RD_SET) || (st_q == ST_RD_LOW)
                 || (st_q == ST_RD_GAP));
    busy_o   = !((st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_FAIL));
    done_o   = (st_q == ST_DONE);
    err_o    = (st_q == ST_FAIL);
  end

  // R2: write strobe only under chip select
  a_r2_wr_under_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> !cs_no);

  // R2: bus still driven when the write strobe releases
  a_r2_bus_at_wr_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> bus_oe_o);

  // R4: bus released and chip select held during a read strobe
  a_r4_rd_bus_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!bus_oe_o && !cs_no));

  // R9: done is a single-cycle pulse outside busy
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);

  // R10: error pulse never overlaps a done pulse or a read
  a_r10_err_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!done_o && rd_no));

  // R11: configuration is frozen while busy
  a_r11_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(bus_o));

endmodule

// File: tb/pbadc_seq_tb.sv
module pbadc_seq_tb_top;
  localparam int CLK_DIV    = 2;
  localparam int WDOG_LIMIT = 32;
  localparam int STROBE_CYC = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       req_i;
  logic [4:0] chan_i;
  logic       uns_i, res8_i, left_i;
  logic       busy_o, done_o, err_o;
  logic [9:0] data_o;
  logic       adc_clk_o, cs_no, wr_no, rd_no;
  logic       int_ni;
  logic [7:0] bus_o, bus_i;
  logic       bus_oe_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // converter model state
  int         m_delay, m_cnt, m_wr_cnt, m_rd_cnt, m_viol_cs, m_viol_oe, m_viol_early;
  bit         m_int_seen, m_cfg_oe;
  logic [7:0] m_cfg, m_b0, m_b1;
  logic       prev_wr, prev_rd;

  always #4 clk_i = ~clk_i;

  pbadc_seq #(.CLK_DIV(CLK_DIV), .WDOG_LIMIT(WDOG_LIMIT), .STROBE_CYC(STROBE_CYC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .chan_i(chan_i), .uns_i(uns_i),
    .res8_i(res8_i), .left_i(left_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .data_o(data_o), .adc_clk_o(adc_clk_o), .cs_no(cs_no), .wr_no(wr_no), .rd_no(rd_no),
    .int_ni(int_ni), .bus_o(bus_o), .bus_oe_o(bus_oe_o), .bus_i(bus_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear(input int delay);
    m_delay = delay; m_cnt = 0; m_wr_cnt = 0; m_rd_cnt = 0;
    m_viol_cs = 0; m_viol_oe = 0; m_viol_early = 0; m_int_seen = 1'b0;
  endtask

  // converter model, acting only at falling clock edges
  initial begin
    int_ni = 1'b1; bus_i = 8'h00; prev_wr = 1'b1; prev_rd = 1'b1;
    m_cfg = 8'h00; m_cfg_oe = 1'b0; m_b0 = 8'h00; m_b1 = 8'h00;
    model_clear(0);
    forever begin
      @(negedge clk_i);
      if (!wr_no && cs_no) m_viol_cs++;
      if (!rd_no && cs_no) m_viol_cs++;
      if (!rd_no && bus_oe_o) m_viol_oe++;
      if (!wr_no && !bus_oe_o) m_viol_oe++;
      if (!rd_no && !m_int_seen) m_viol_early++;
      if (!prev_wr && wr_no) begin
        m_cfg = bus_o; m_cfg_oe = bus_oe_o; m_wr_cnt++;
        m_rd_cnt = 0; m_int_seen = 1'b0; m_cnt = m_delay;
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin int_ni = 1'b0; m_int_seen = 1'b1; end
      end
      if (!rd_no) begin
        bus_i = (m_rd_cnt == 0) ? m_b0 : m_b1;
        int_ni = 1'b1;
      end else begin
        bus_i = 8'h00;
      end
      if (!prev_rd && rd_no) m_rd_cnt++;
      prev_wr = wr_no; prev_rd = rd_no;
    end
  end

  task automatic request(input logic [4:0] ch, input logic u, input logic r8, input logic lf);
    @(negedge clk_i);
    req_i = 1'b1; chan_i = ch; uns_i = u; res8_i = r8; left_i = lf;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_end(output int cyc);
    cyc = 1;
    while (!done_o && !err_o && cyc < 3000) begin
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; req_i = 1'b0; chan_i = '0; uns_i = 0; res8_i = 0; left_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 cs_no in reset", cs_no, 1);
    chk("R1 busy in reset", busy_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 strobes idle", {cs_no, wr_no, rd_no}, 3'b111);
    chk("R1 flags idle", {bus_oe_o, busy_o, done_o, err_o}, 4'b0000);
  endtask

  task automatic t_clock;
    int c0 = 0, period = 0;
    logic prev = adc_clk_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (!prev && adc_clk_o) begin
        if (c0 != 0 && period == 0) period = i - c0;
        if (c0 == 0) c0 = i;
      end
      prev = adc_clk_o;
    end
    chk("R12 converter clock period", period, 2 * CLK_DIV);
  endtask

  task automatic t_8bit;
    int cyc;
    model_clear(10); m_b0 = 8'hC3; m_b1 = 8'h5A;
    request(5'd5, 1'b1, 1'b1, 1'b0);
    chk("R9 busy after accept", busy_o, 1);
    wait_end(cyc);
    chk("R9 done pulse 8-bit", done_o, 1);
    chk("R9 busy low at done", busy_o, 0);
    chk("R6 data 8-bit", data_o, 10'h0C3);
    chk("R3 cfg byte 8-bit", m_cfg, {1'b0, 1'b1, 1'b1, 5'd5});
    chk("R2 bus driven at wr rise", m_cfg_oe, 1);
    chk("R2 one write", m_wr_cnt, 1);
    @(negedge clk_i);
    chk("R6 one read", m_rd_cnt, 1);
    chk("R9 done single cycle", done_o, 0);
    chk("R2 R4 cs and bus ownership", m_viol_cs + m_viol_oe, 0);
    chk("R5 no early read", m_viol_early, 0);
  endtask

  task automatic t_10bit_right;
    int cyc;
    model_clear(14); m_b0 = 8'h34; m_b1 = 8'h02;
    request(5'd18, 1'b0, 1'b0, 1'b0);
    wait_end(cyc);
    chk("R7 done 10-bit right", done_o, 1);
    chk("R7 data 10-bit right", data_o, 10'h234);
    chk("R3 cfg byte right", m_cfg, {1'b0, 1'b0, 1'b0, 5'd18});
    @(negedge clk_i);
    chk("R7 two reads", m_rd_cnt, 2);
    chk("R4 R5 bus rules right", m_viol_cs + m_viol_oe + m_viol_early, 0);
  endtask

  task automatic t_10bit_left;
    int cyc;
    model_clear(22); m_b0 = 8'h8D; m_b1 = 8'h40;
    request(5'd31, 1'b1, 1'b0, 1'b1);
    wait_end(cyc);
    chk("R8 done 10-bit left", done_o, 1);
    chk("R8 data 10-bit left", data_o, 10'h235);
    chk("R3 cfg byte left", m_cfg, {1'b1, 1'b0, 1'b1, 5'd31});
    @(negedge clk_i);
    chk("R8 two reads", m_rd_cnt, 2);
  endtask

  task automatic t_timeout;
    int cyc;
    int lo = (WDOG_LIMIT - 1) * 2 * CLK_DIV;
    int hi = WDOG_LIMIT * 2 * CLK_DIV + 12;
    model_clear(0);
    request(5'd9, 1'b0, 1'b1, 1'b0);
    wait_end(cyc);
    chk("R10 err pulse", err_o, 1);
    chk("R10 no done on timeout", done_o, 0);
    chk("R10 window lower bound", cyc >= lo, 1);
    chk("R10 window upper bound", cyc <= hi, 1);
    chk("R10 no read on timeout", m_rd_cnt, 0);
    @(negedge clk_i);
    chk("R10 idle after err", {err_o, busy_o}, 2'b00);
    model_clear(6); m_b0 = 8'h77;
    request(5'd1, 1'b0, 1'b1, 1'b0);
    wait_end(cyc);
    chk("R10 recovers after err", {done_o, data_o}, {1'b1, 10'h077});
  endtask

  task automatic t_busy_ignore;
    int cyc;
    bit busy_drop = 1'b0;
    model_clear(30); m_b0 = 8'h11;
    request(5'd3, 1'b0, 1'b1, 1'b0);
    repeat (8) @(negedge clk_i);
    req_i = 1'b1; chan_i = 5'd7; res8_i = 1'b0; left_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    wait_end(cyc);
    chk("R11 first conversion done", {done_o, data_o}, {1'b1, 10'h011});
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (busy_o) busy_drop = 1'b1;
    end
    chk("R11 no second start", busy_drop, 0);
    chk("R11 single write", m_wr_cnt, 1);
    chk("R11 cfg unchanged", m_cfg, {1'b0, 1'b1, 1'b0, 5'd3});
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clock();
    t_8bit();
    t_10bit_right();
    t_10bit_left();
    t_timeout();
    t_busy_ignore();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule